// File: doc/BRIEF.md
# Free-Running Timer with Sticky Status Flags

A 16-bit up-counter that advances once per cycle while its count enable is high, with two 16-bit compare registers and a single capture event strobe. Four sticky event flags live in one 8-bit status register: overflow of the counter, a match against either compare register, and arrival of a capture event. Hardware is the only agent that can set a flag.

Software reaches the counter, the compare registers and the status register over a small byte-wide register bus. The bus has a 3-bit address, a read strobe, a write strobe, write data and combinational read data. A flag is cleared by a two-step handshake. Software first reads the status register while the flag is 1, which arms that flag. It then writes 0 to that flag's bit. A zero write to a flag that is not armed leaves the flag set, and writing 1 never changes a flag. This protects the flags against a blind write wiping out an event that software has not yet seen.

Top module: `frt_status_timer`

## Requirements
- R1: After reset the counter reads 0x0000, every status flag reads 0, and both compare registers read 0xFFFF.
- R2: While cnt_en_i is high the counter increases by one per clock and wraps from 0xFFFF to 0x0000; while it is low the counter holds. A bus write to the counter's high byte (address 1) or low byte (address 2) replaces that byte, and that cycle takes priority over the increment.
- R3: The overflow flag (status bit 1) is set on the clock edge where an increment takes the counter from 0xFFFF to 0x0000.
- R4: Compare flag A (status bit 3) is set when an increment produces a counter value equal to compare register A, whose bytes are at address 3 (high) and 4 (low). Compare flag B (status bit 2) is set the same way against compare register B, whose bytes are at address 5 (high) and 6 (low).
- R5: The capture flag (status bit 4) is set on the clock edge that samples cap_i high.
- R6: A bus write of 1 to any flag bit of the status register (address 0) never sets or changes that flag.
- R7: A bus write of 0 to a flag bit clears the flag only if a status read has returned that flag as 1 since the flag was last set. Without that read, the flag stays 1.
- R8: When a hardware set and a valid clear of the same flag fall in one cycle, the flag stays 1 and its arming is dropped, so a later zero write without a new read does not clear it.
- R9: Status bits 7..5 and bit 0 always read 0, and address 7 reads 0x00. rdata_o is 0x00 whenever rd_i is low.
- R10: A bus write that loads the counter with a compare value does not set that compare flag. While the counter is held at a matching value, the flag is not set again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter advance enable (one count per cycle while high) |
| cap_i | input | 1 | Capture event strobe |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, valid while rd_i is high |

## Verification
The bench goes after the clear handshake. It issues a zero write with no preceding read, which a design that ignored arming would treat as a clear. It writes ones to the flag bits, which a design with a plain writable register would take as a set. It lands a capture event in the same cycle as an armed clear, which a design with clear-over-set priority, or one that kept the arming, would let wipe out the new event. It also loads the counter directly with a compare value and stalls it on a match, where a design comparing the register value rather than the increment result would raise the flag spuriously or raise it again after the clear. The 0xFFFF wrap and the write-versus-increment priority are checked at exact counter values.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned DataW   = 8;
  localparam int unsigned AddrW   = 3;
  localparam int unsigned NumFlag = 4;
  localparam int unsigned FlagLo  = 1;  // flags occupy status bits [FlagLo+NumFlag-1:FlagLo]

  typedef enum logic [AddrW-1:0] {
    ADDR_STAT   = 3'd0,
    ADDR_CNT_HI = 3'd1,
    ADDR_CNT_LO = 3'd2,
    ADDR_CPA_HI = 3'd3,
    ADDR_CPA_LO = 3'd4,
    ADDR_CPB_HI = 3'd5,
    ADDR_CPB_LO = 3'd6
  } frt_addr_e;

  // index into the flag vector (bit = FlagLo + index)
  localparam int unsigned FL_OVF = 0;
  localparam int unsigned FL_CPB = 1;
  localparam int unsigned FL_CPA = 2;
  localparam int unsigned FL_CAP = 3;
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned DataW = 8,
  localparam int unsigned CntW = 2 * DataW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [DataW-1:0] wdata_i,
  output logic [CntW-1:0]  cnt_o,
  output logic [CntW-1:0]  nxt_o,
  output logic             inc_o,
  output logic             wrap_o
);
  logic [CntW-1:0] cnt_q, cnt_d;
  logic            sw_wr;

  assign sw_wr  = wr_hi_i | wr_lo_i;
  assign inc_o  = en_i & ~sw_wr;
  assign nxt_o  = cnt_q + CntW'(1);
  assign wrap_o = inc_o & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_hi_i)    cnt_d[CntW-1:DataW] = wdata_i;
    if (wr_lo_i)    cnt_d[DataW-1:0]    = wdata_i;
    if (inc_o)      cnt_d               = nxt_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_hi_i && !wr_lo_i) |=> (cnt_q == $past(cnt_q) + CntW'(1)));
  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_hi_i && !wr_lo_i) |=> $stable(cnt_q));
endmodule

// File: rtl/frt_cmp_reg.sv
module frt_cmp_reg #(
  parameter int unsigned DataW = 8,
  localparam int unsigned CntW = 2 * DataW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [DataW-1:0] wdata_i,
  input  logic             inc_i,
  input  logic [CntW-1:0]  nxt_i,
  output logic [CntW-1:0]  cmp_o,
  output logic             match_o
);
  logic [CntW-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
    end else begin
      if (wr_hi_i) cmp_q[CntW-1:DataW] <= wdata_i;
      if (wr_lo_i) cmp_q[DataW-1:0]    <= wdata_i;
    end
  end

  // match is judged on the incremented value only, never on a software load
  assign match_o = inc_i & (nxt_i == cmp_q);
  assign cmp_o   = cmp_q;
endmodule

// File: rtl/frt_flag_cell.sv
module frt_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_i && armed_q) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  assert_no_sw_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !set_i) |=> !flag_q);
  assert_clear_needs_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !armed_q && !set_i) |=> flag_q);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (flag_q && !armed_q));
  assert_read_arms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && flag_q && !set_i && !clr_i) |=> armed_q);
endmodule

// File: rtl/frt_status_timer.sv
module frt_status_timer
  import frt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             cap_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DataW-1:0] wdata_i,
  output logic [DataW-1:0] rdata_o
);
  localparam int unsigned CntW   = 2 * DataW;
  localparam int unsigned NumCmp = 2;

  logic [CntW-1:0]    cnt, nxt;
  logic               inc, wrap;
  logic [CntW-1:0]    cmp_val [NumCmp];
  logic [NumCmp-1:0]  cmp_match;
  logic [NumCmp-1:0]  cmp_wr_hi, cmp_wr_lo;
  logic [NumFlag-1:0] flag_set, flags;
  logic               stat_rd, stat_wr;

  frt_counter #(.DataW(DataW)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en_i),
    .wr_hi_i (wr_i && addr_i == ADDR_CNT_HI),
    .wr_lo_i (wr_i && addr_i == ADDR_CNT_LO),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .nxt_o   (nxt),
    .inc_o   (inc),
    .wrap_o  (wrap)
  );

  // channel 0 = A (addr 3/4), channel 1 = B (addr 5/6)
  assign cmp_wr_hi[0] = wr_i && addr_i == ADDR_CPA_HI;
  assign cmp_wr_lo[0] = wr_i && addr_i == ADDR_CPA_LO;
  assign cmp_wr_hi[1] = wr_i && addr_i == ADDR_CPB_HI;
  assign cmp_wr_lo[1] = wr_i && addr_i == ADDR_CPB_LO;

  for (genvar c = 0; c < NumCmp; c++) begin : g_cmp
    frt_cmp_reg #(.DataW(DataW)) i_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_hi_i (cmp_wr_hi[c]),
      .wr_lo_i (cmp_wr_lo[c]),
      .wdata_i (wdata_i),
      .inc_i   (inc),
      .nxt_i   (nxt),
      .cmp_o   (cmp_val[c]),
      .match_o (cmp_match[c])
    );
  end

  assign flag_set[FL_OVF] = wrap;
  assign flag_set[FL_CPB] = cmp_match[1];
  assign flag_set[FL_CPA] = cmp_match[0];
  assign flag_set[FL_CAP] = cap_i;

  assign stat_rd = rd_i && addr_i == ADDR_STAT;
  assign stat_wr = wr_i && addr_i == ADDR_STAT;

  for (genvar f = 0; f < NumFlag; f++) begin : g_flag
    frt_flag_cell i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[f]),
      .rd_i   (stat_rd),
      .clr_i  (stat_wr && !wdata_i[FlagLo+f]),
      .flag_o (flags[f])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_STAT:   rdata_o[FlagLo +: NumFlag] = flags;
        ADDR_CNT_HI: rdata_o = cnt[CntW-1:DataW];
        ADDR_CNT_LO: rdata_o = cnt[DataW-1:0];
        ADDR_CPA_HI: rdata_o = cmp_val[0][CntW-1:DataW];
        ADDR_CPA_LO: rdata_o = cmp_val[0][DataW-1:0];
        ADDR_CPB_HI: rdata_o = cmp_val[1][CntW-1:DataW];
        ADDR_CPB_LO: rdata_o = cmp_val[1][DataW-1:0];
        default:     rdata_o = '0;
      endcase
    end
  end

  assert_unused_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_STAT) |-> (rdata_o[7:5] == 3'b000 && rdata_o[0] == 1'b0));
  assert_idle_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
  assert_wrap_sets_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !wr_i && cnt == '1) |=> (flags[FL_OVF] && cnt == '0));
endmodule

// File: tb/test_frt_status_timer.sv
module test_frt_status_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_en_i = 1'b0;
  logic       cap_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  frt_status_timer i_frt_status_timer (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(3'd1, h);
    bus_rd(3'd2, l);
    v = {h, l};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    bus_wr(3'd1, v[15:8]);
    bus_wr(3'd2, v[7:0]);
  endtask

  task automatic run(input int n);
    @(negedge clk_i);
    cnt_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cnt_en_i = 1'b0;
  endtask

  task automatic clear_all();
    logic [7:0] s;
    bus_rd(3'd0, s);
    bus_wr(3'd0, 8'h00);
    bus_rd(3'd0, s);
    chk("clear_all", 16'(s), 16'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic [15:0] v;
    rd_cnt(v);              chk("R1 counter", v, 16'h0000);
    bus_rd(3'd0, d);        chk("R1 status", 16'(d), 16'h00);
    bus_rd(3'd3, d);        chk("R1 cmpA hi", 16'(d), 16'hFF);
    bus_rd(3'd6, d);        chk("R1 cmpB lo", 16'(d), 16'hFF);
    @(negedge clk_i); #1;   chk("R9 idle rdata", 16'(rdata_o), 16'h00);
    bus_rd(3'd7, d);        chk("R9 addr7", 16'(d), 16'h00);
  endtask

  task automatic t_count();
    logic [15:0] v;
    set_cnt(16'h1234);
    rd_cnt(v);  chk("R2 load", v, 16'h1234);
    run(5);
    rd_cnt(v);  chk("R2 run5", v, 16'h1239);
    repeat (4) @(negedge clk_i);
    rd_cnt(v);  chk("R2 hold", v, 16'h1239);
    // write during enable: write wins that cycle, then counting resumes
    @(negedge clk_i);
    cnt_en_i = 1'b1; addr_i = 3'd2; wdata_i = 8'h80; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    cnt_en_i = 1'b0;
    rd_cnt(v);  chk("R2 write priority", v, 16'h1282);
    clear_all();
  endtask

  task automatic t_overflow();
    logic [7:0] s;
    logic [15:0] v;
    set_cnt(16'hFFFE);
    run(1);
    bus_rd(3'd0, s); chk("R3 no ovf at FFFF", 16'(s[1]), 16'h0);
    run(1);
    rd_cnt(v);       chk("R2 wrap", v, 16'h0000);
    bus_rd(3'd0, s); chk("R3 ovf set", 16'(s[1]), 16'h1);
    clear_all();
  endtask

  task automatic t_compare();
    logic [7:0] s;
    bus_wr(3'd3, 8'h20); bus_wr(3'd4, 8'h10);
    bus_wr(3'd5, 8'h20); bus_wr(3'd6, 8'h13);
    set_cnt(16'h200E);
    clear_all();
    run(1);
    bus_rd(3'd0, s); chk("R4 none yet", 16'(s), 16'h00);
    run(1);
    bus_rd(3'd0, s); chk("R4 A only", 16'(s), 16'h08);
    run(3);
    bus_rd(3'd0, s); chk("R4 A and B", 16'(s), 16'h0C);
    clear_all();
  endtask

  task automatic t_capture_and_protocol();
    logic [7:0] s;
    @(negedge clk_i); cap_i = 1'b1;
    @(negedge clk_i); cap_i = 1'b0;
    bus_rd(3'd0, s); chk("R5 cap set", 16'(s), 16'h10);
    clear_all();
    // set again, write 0 without read
    @(negedge clk_i); cap_i = 1'b1;
    @(negedge clk_i); cap_i = 1'b0;
    bus_wr(3'd0, 8'h00);
    bus_rd(3'd0, s); chk("R7 blind zero write keeps flag", 16'(s), 16'h10);
    // that read armed it; writing 1 must not clear or disturb
    bus_wr(3'd0, 8'hFF);
    bus_rd(3'd0, s); chk("R6 write one no effect", 16'(s), 16'h10);
    bus_wr(3'd0, 8'h00);
    bus_rd(3'd0, s); chk("R7 read then zero clears", 16'(s), 16'h00);
    bus_wr(3'd0, 8'hFF);
    bus_rd(3'd0, s); chk("R6 write one cannot set", 16'(s), 16'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] s;
    @(negedge clk_i); cap_i = 1'b1;
    @(negedge clk_i); cap_i = 1'b0;
    bus_rd(3'd0, s);
    @(negedge clk_i);
    addr_i = 3'd0; wdata_i = 8'h00; wr_i = 1'b1; cap_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; cap_i = 1'b0;
    bus_wr(3'd0, 8'h00);
    bus_rd(3'd0, s); chk("R8 set wins and disarms", 16'(s), 16'h10);
    clear_all();
  endtask

  task automatic t_no_match_on_load();
    logic [7:0] s;
    bus_wr(3'd3, 8'h01); bus_wr(3'd4, 8'h00);
    set_cnt(16'h0100);
    bus_rd(3'd0, s); chk("R10 load no match", 16'(s[3]), 16'h0);
    set_cnt(16'h00FF);
    clear_all();
    run(1);
    bus_rd(3'd0, s); chk("R10 increment match", 16'(s[3]), 16'h1);
    bus_wr(3'd0, 8'h00);
    repeat (5) @(negedge clk_i);
    bus_rd(3'd0, s); chk("R10 stalled no rematch", 16'(s[3]), 16'h0);
    chk("R9 unused bits", 16'({s[7:5], s[0]}), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_count();
    t_overflow();
    t_compare();
    t_capture_and_protocol();
    t_set_wins();
    t_no_match_on_load();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule